// File: doc/BRIEF.md
# Sprite Page Copy Engine

This block fills a 256-byte sprite attribute store in one of two ways. A CPU write of a page number to a trigger register starts a block copy. The engine then takes the system memory bus, reads the 256 bytes of that page in ascending order and writes each one into the sprite store, beginning at sprite address zero. While the copy runs it holds the CPU stalled. When the copy is finished it drops the stall and raises a one-cycle done pulse.

Software can also load the store a byte at a time. One register sets a sprite-store pointer. Each write to a second register stores its data byte at the pointer and then advances the pointer. A combinational read port exposes the stored bytes to the rest of the chip.

Top module: `sprite_dma`

## Requirements
- R1: After reset, stall, done, bus_rd and spr_we are all low.
- R2: A CPU write of byte P to address 0x4014 while idle starts a copy, and stall is high from the very next cycle.
- R3: The copy reads the source addresses P*256+0 through P*256+255 in ascending order, with bus_rd high in each read cycle.
- R4: Every read cycle is followed by one write cycle. In that cycle spr_we is high, spr_addr equals the low byte of the address just read (so the destination begins at 0), and spr_wdata equals the byte that was read.
- R5: stall stays high for exactly 512 consecutive cycles, made of 256 read cycles that alternate with 256 write cycles.
- R6: done is high for exactly one cycle: the first cycle after stall falls.
- R7: A write to 0x4014 during a copy has no effect. The copy neither restarts nor changes its source page.
- R8: A write to 0x2003 sets the 8-bit sprite pointer. Each write to 0x2004 stores its byte at the pointer and then increments the pointer, wrapping from 0xFF to 0x00. A copy leaves the pointer unchanged.
- R9: Writes to 0x2003 or 0x2004 during a copy are ignored. They change neither the pointer nor the stored contents.
- R10: rd_data always shows the stored byte at rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| bus_addr | output | 16 | Source address driven during a copy |
| bus_rd | output | 1 | Read strobe on the memory bus |
| bus_rdata | input | 8 | Data returned by the memory bus |
| spr_we | output | 1 | Sprite store write enable |
| spr_addr | output | 8 | Sprite store write address |
| spr_wdata | output | 8 | Sprite store write data |
| stall | output | 1 | Holds the CPU while a copy runs |
| done | output | 1 | One-cycle pulse when a copy ends |
| rd_addr | input | 8 | Sprite store read address |
| rd_data | output | 8 | Sprite store read data |

## Verification
The hardest case to reach is register traffic that arrives while a copy is in progress. A real CPU would be stalled and could not send it, so the bench forces these writes into the middle of the copy. It issues a second trigger, a pointer write and a data write at fixed cycle counts inside the stall window. It then checks that the stall still lasts 512 cycles, that every source address still belongs to the first page, and that the whole store matches that page. Finally, a manual write made after the copy shows that the pointer kept its value from before the copy.

// File: rtl/sprite_dma.sv
module sprite_dma #(
  parameter int DW = 8,
  parameter int IW = 8,
  parameter logic [15:0] TRIG_ADDR = 16'h4014,
  parameter logic [15:0] PTR_ADDR  = 16'h2003,
  parameter logic [15:0] DATA_ADDR = 16'h2004
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_wr,
  input  logic [15:0]   cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [15:0]   bus_addr,
  output logic          bus_rd,
  input  logic [DW-1:0] bus_rdata,
  output logic          spr_we,
  output logic [IW-1:0] spr_addr,
  output logic [DW-1:0] spr_wdata,
  output logic          stall,
  output logic          done,
  input  logic [IW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << IW;
  localparam int PW = 16 - IW;

  logic          busy, phase, done_q;
  logic [IW-1:0] cnt, ptr;
  logic [PW-1:0] page;
  logic [DW-1:0] hold;
  logic [DW-1:0] mem [DEPTH];

  wire trig    = cpu_wr && cpu_addr == TRIG_ADDR && !busy;
  wire set_ptr = cpu_wr && cpu_addr == PTR_ADDR  && !busy;
  wire put_dat = cpu_wr && cpu_addr == DATA_ADDR && !busy;

  assign bus_rd    = busy && !phase;
  assign bus_addr  = {page, cnt};
  assign spr_we    = (busy && phase) || put_dat;
  assign spr_addr  = busy ? cnt : ptr;
  assign spr_wdata = busy ? hold : cpu_wdata;
  assign stall     = busy;
  assign done      = done_q;
  assign rd_data   = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
      ptr    <= '0;
      page   <= '0;
      hold   <= '0;
    end else begin
      done_q <= 1'b0;
      if (trig) begin
        busy  <= 1'b1;
        phase <= 1'b0;
        cnt   <= '0;
        page  <= PW'(cpu_wdata);
      end else if (busy) begin
        if (!phase) begin
          hold  <= bus_rdata;
          phase <= 1'b1;
        end else begin
          phase <= 1'b0;
          cnt   <= cnt + 1'b1;
          if (&cnt) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
      if (set_ptr) ptr <= IW'(cpu_wdata);
      else if (put_dat) ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (spr_we) mem[spr_addr] <= spr_wdata;
endmodule

// File: rtl/sprite_dma_checker.sv
module sprite_dma_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_wr,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic [15:0] bus_addr,
  input logic        bus_rd,
  input logic [7:0]  bus_rdata,
  input logic        spr_we,
  input logic [7:0]  spr_addr,
  input logic [7:0]  spr_wdata,
  input logic        stall,
  input logic        done
);
  assert_start_on_trigger_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(cpu_wr && cpu_addr == 16'h4014));

  assert_first_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> (bus_rd && bus_addr == {$past(cpu_wdata), 8'h00}));

  assert_read_then_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && bus_rd) |=> (spr_we && !bus_rd && spr_addr == $past(bus_addr[7:0])
                           && spr_wdata == $past(bus_rdata)));

  assert_write_then_next_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && spr_we && spr_addr != 8'hFF) |=> (bus_rd && bus_addr[7:0] == $past(spr_addr) + 8'd1));

  assert_done_after_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!stall && $past(stall)));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind sprite_dma sprite_dma_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
  .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .spr_we(spr_we),
  .spr_addr(spr_addr), .spr_wdata(spr_wdata), .stall(stall), .done(done)
);

// File: tb/tb_sprite_dma.sv
module tb_sprite_dma;
  logic clk = 0, rst_n = 0, cpu_wr = 0;
  logic [15:0] cpu_addr = 0, bus_addr;
  logic [7:0] cpu_wdata = 0, bus_rdata, spr_addr, spr_wdata, rd_addr = 0, rd_data;
  logic bus_rd, spr_we, stall, done;
  int checks = 0, errors = 0;
  logic [7:0] exp_mem [256];

  always #10 clk = ~clk;

  function automatic logic [7:0] src(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction
  assign bus_rdata = src(bus_addr);

  sprite_dma dut (.clk, .rst_n, .cpu_wr, .cpu_addr, .cpu_wdata, .bus_addr, .bus_rd,
    .bus_rdata, .spr_we, .spr_addr, .spr_wdata, .stall, .done, .rd_addr, .rd_data);

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk); cpu_wr = 0;
  endtask

  task automatic compare_all(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) begin
      rd_addr = 8'(i); #1;
      if (rd_data !== exp_mem[i]) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic run_dma(input logic [7:0] page, input bit inject);
    int n = 0, rds = 0, bad_addr = 0;
    wr(16'h4014, page);
    chk(stall === 1'b1, "R2 stall after trigger", stall, 1);
    while (stall === 1'b1 && n < 2000) begin
      if (bus_rd) begin
        if (bus_addr !== {page, 8'(rds)}) bad_addr++;
        rds++;
      end
      n++;
      cpu_wr = 0;
      if (inject) begin
        if (n == 10) begin cpu_wr = 1; cpu_addr = 16'h4014; cpu_wdata = 8'h07; end
        if (n == 20) begin cpu_wr = 1; cpu_addr = 16'h2003; cpu_wdata = 8'h40; end
        if (n == 30) begin cpu_wr = 1; cpu_addr = 16'h2004; cpu_wdata = 8'h33; end
      end
      @(negedge clk);
    end
    cpu_wr = 0;
    chk(n == 512, inject ? "R7 stall length with injected trigger" : "R5 stall length", n, 512);
    chk(rds == 256, "R5 read cycle count", rds, 256);
    chk(bad_addr == 0, "R3 source address order", bad_addr, 0);
    chk(done === 1'b1, "R6 done after stall", done, 1);
    @(negedge clk);
    chk(done === 1'b0 && stall === 1'b0, "R6 done one cycle, R7 no restart", {stall, done}, 0);
    for (int i = 0; i < 256; i++) exp_mem[i] = src({page, 8'(i)});
    compare_all(inject ? "R9 contents after ignored writes" : "R4 R10 contents after copy");
  endtask

  task automatic t_reset;
    chk({stall, done, bus_rd, spr_we} === 4'b0, "R1 reset outputs", {stall, done, bus_rd, spr_we}, 0);
  endtask

  task automatic t_manual_wrap;
    wr(16'h2003, 8'hFE);
    wr(16'h2004, 8'hA1);
    wr(16'h2004, 8'hA2);
    wr(16'h2004, 8'hA3);
    exp_mem[8'hFE] = 8'hA1; exp_mem[8'hFF] = 8'hA2; exp_mem[8'h00] = 8'hA3;
    compare_all("R8 manual writes with wrap");
  endtask

  task automatic t_pointer_kept;
    wr(16'h2004, 8'h77);
    exp_mem[8'h01] = 8'h77;
    rd_addr = 8'h01; #1;
    chk(rd_data === 8'h77, "R8 R9 pointer kept across copy", rd_data, 8'h77);
    rd_addr = 8'h40; #1;
    chk(rd_data === exp_mem[8'h40], "R9 ignored pointer write", rd_data, exp_mem[8'h40]);
    compare_all("R8 contents after pointer write");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    run_dma(8'h02, 0);
    t_manual_wrap();
    run_dma(8'hFF, 1);
    t_pointer_kept();
    run_dma(8'h00, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule